// File: doc/BRIEF.md
# Host Doorbell and Interrupt Register Block

This block is the device-side register window through which a host processor and a storage controller's firmware exchange commands and completions. The host reaches it over a plain 32-bit register bus with byte enables. Every control register in the window has one address that reads or sets it and a second address that clears it. Commands travel inward as one-cycle strobes to firmware. Completions and errors travel outward as sticky flags that the host acknowledges by writing ones.

The firmware side posts completions together with a 16-bit command identifier and a 16-bit status. It can also raise an error carrying a 5-bit code and two parameter bytes, mark the hardware mailbox as taken, and report that initialization is still running. A 64-bit mailbox bus address, written by the host in two words, is presented to the fetch logic.

The block drives one level interrupt toward the host. That interrupt is the OR of the two outbound completion flags, each gated by its own mask bit. A mask bit of one disables its source, and both mask bits are set after reset.

Top module: `mbx_doorbell_regs`

## Requirements
- R1: The decoded window covers byte addresses 0x000 to 0x5FF. A read at or above 0x600 returns zero, and a write there changes nothing and raises no strobe, even when its low bits match a register.
- R2: A write to 0x214 produces one-cycle strobes in the cycle after the write. Bit 24 gives hardware-mailbox command, bit 26 gives firmware interrupt request, bit 27 gives controller reset, and bit 28 gives memory-mailbox command. A write to 0x218 with bit 25 set produces the hardware-status acknowledge strobe.
- R3: A read of 0x214 or 0x218 returns mailbox-full in bit 24 and the firmware's init-busy level in bit 25, with all other bits zero. Mailbox-full is set by a hardware-mailbox command write and cleared by the firmware's taken strobe.
- R4: A read of 0x224 or 0x228 returns hardware-mailbox status available in bit 24 and memory-mailbox status available in bit 25. These bits are set by the firmware done strobes and cleared by writing ones at 0x228. A post and a clear of the same bit in the same cycle leave the bit set.
- R5: The mask holds bits 24 (hardware) and 25 (memory). Writing ones at 0x22C sets mask bits and writing ones at 0x230 clears them. Either address reads the mask, and reset leaves both bits set.
- R6: The host interrupt is high exactly when some outbound flag is set and its mask bit is clear. It follows a post or a mask change from the cycle after the causing edge.
- R7: Words written at 0x510 (low) and 0x514 (high) form the 64-bit mailbox address output. A write of the high word pulses the load output for one cycle. Address 0x514 reads back the high word.
- R8: A read of 0x518 returns the command identifier in bits 15:0 and the command status in bits 31:16. Both are latched on either firmware done strobe.
- R9: A firmware error strobe sets error-pending at bit 29 of 0x224 and places its 5-bit code in bits 31:30 (code[4:3]) and 28:26 (code[2:0]). Parameter byte 0 reads at bits 7:0 and parameter byte 1 at bits 15:8 of 0x510. A write at 0x228 with both bits 25 and 24 set clears the pending flag and the code; a write with only one of them set does not.
- R10: A read of 0x208 returns, in bits 25:24, the outbound flags that are set and unmasked.
- R11: In the cycle the controller-reset strobe is high, the outbound flags, the error state, mailbox-full and the command identifier and status are forced to zero, and firmware posts in that cycle are dropped. The mask and the mailbox address are kept.
- R12: A write bit takes effect only when the byte enable of its lane is set, and partial writes to the address words merge byte by byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | ADDR_W | Host byte address |
| bus_wdata | input | 32 | Host write data |
| bus_be | input | 4 | Host byte enables |
| bus_we | input | 1 | Host write strobe |
| bus_re | input | 1 | Host read strobe |
| bus_rdata | output | 32 | Read data, valid the cycle after bus_re |
| fw_mbox_taken | input | 1 | Firmware has taken the hardware mailbox |
| fw_init_busy | input | 1 | Firmware initialization running (level) |
| fw_hw_done | input | 1 | Post hardware-mailbox completion |
| fw_mem_done | input | 1 | Post memory-mailbox completion |
| fw_cmd_id | input | 16 | Command identifier latched on a post |
| fw_cmd_status | input | 16 | Command status latched on a post |
| fw_err | input | 1 | Raise an error |
| fw_err_code | input | 5 | Error code |
| fw_err_p0 | input | 8 | Error parameter byte 0 |
| fw_err_p1 | input | 8 | Error parameter byte 1 |
| fw_hw_cmd | output | 1 | Hardware-mailbox command strobe |
| fw_hw_ack | output | 1 | Hardware-status acknowledge strobe |
| fw_irq_req | output | 1 | Interrupt request to firmware strobe |
| fw_ctl_rst | output | 1 | Controller reset strobe |
| fw_mem_cmd | output | 1 | Memory-mailbox command strobe |
| mbox_addr | output | 64 | Mailbox bus address |
| mbox_addr_load | output | 1 | High address word written |
| host_irq | output | 1 | Level interrupt to host |

## Verification
A host write takes effect at the clock edge that samples it. Register state, strobes and the host interrupt therefore show the new value in the following cycle, and the bench samples them at the falling edge right after that write edge. Read data is registered, so it appears one cycle after the read strobe and is sampled at the next falling edge. It reflects state as it stood before that edge. Firmware strobes are held across exactly one rising edge, and same-cycle collisions (post against clear, post during controller reset) are driven on the same falling edge so that both land on one rising edge.

// File: rtl/mbx_pkg.sv
package mbx_pkg;

    localparam int WORD_W = 32;
    localparam int NSRC   = 2;
    localparam int ERR_W  = 5;

    // byte offsets within the window
    localparam logic [11:0] WIN_SIZE    = 12'h600;
    localparam logic [11:0] OFS_ISR     = 12'h208;
    localparam logic [11:0] OFS_IB_SET  = 12'h214;
    localparam logic [11:0] OFS_IB_CLR  = 12'h218;
    localparam logic [11:0] OFS_OB_RD   = 12'h224;
    localparam logic [11:0] OFS_OB_CLR  = 12'h228;
    localparam logic [11:0] OFS_MSK_SET = 12'h22C;
    localparam logic [11:0] OFS_MSK_CLR = 12'h230;
    localparam logic [11:0] OFS_ADR_LO  = 12'h510;
    localparam logic [11:0] OFS_ADR_HI  = 12'h514;
    localparam logic [11:0] OFS_CMD_ST  = 12'h518;

    // bit positions inside the top byte
    localparam int B_HW     = 24;
    localparam int B_MEM    = 25;
    localparam int B_FWIRQ  = 26;
    localparam int B_RST    = 27;
    localparam int B_MEMCMD = 28;

    typedef struct packed {
        logic isr;
        logic ib_set;
        logic ib_clr;
        logic ob_rd;
        logic ob_clr;
        logic msk_set;
        logic msk_clr;
        logic adr_lo;
        logic adr_hi;
        logic cmd_st;
    } regsel_t;

    typedef struct packed {
        logic hw_cmd;
        logic hw_ack;
        logic fw_irq;
        logic ctl_rst;
        logic mem_cmd;
    } ibpulse_t;

    typedef struct packed {
        logic             pend;
        logic [ERR_W-1:0] code;
        logic [7:0]       p0;
        logic [7:0]       p1;
    } err_t;

    function automatic logic [WORD_W-1:0] lane_mask(input logic [WORD_W/8-1:0] be);
        logic [WORD_W-1:0] m;
        for (int i = 0; i < WORD_W/8; i++) m[8*i +: 8] = {8{be[i]}};
        return m;
    endfunction

    // error code is split around the pending bit
    function automatic logic [7:0] ob_top_byte(input logic [NSRC-1:0] ob, input err_t e);
        return {e.code[4:3], e.pend, e.code[2:0], ob};
    endfunction

endpackage

// File: rtl/mbx_decode.sv
module mbx_decode
    import mbx_pkg::*;
#(
    parameter int ADDR_W = 13
) (
    input  logic [ADDR_W-1:0] addr,
    output logic              in_win,
    output regsel_t           sel
);
    localparam logic [ADDR_W-1:0] WIN = ADDR_W'(WIN_SIZE);

    function automatic logic hit(input logic [ADDR_W-1:0] a, input logic [11:0] ofs);
        return a[ADDR_W-1:2] == ADDR_W'(ofs) >> 2;
    endfunction

    always_comb begin
        in_win     = addr < WIN;
        sel.isr     = in_win && hit(addr, OFS_ISR);
        sel.ib_set  = in_win && hit(addr, OFS_IB_SET);
        sel.ib_clr  = in_win && hit(addr, OFS_IB_CLR);
        sel.ob_rd   = in_win && hit(addr, OFS_OB_RD);
        sel.ob_clr  = in_win && hit(addr, OFS_OB_CLR);
        sel.msk_set = in_win && hit(addr, OFS_MSK_SET);
        sel.msk_clr = in_win && hit(addr, OFS_MSK_CLR);
        sel.adr_lo  = in_win && hit(addr, OFS_ADR_LO);
        sel.adr_hi  = in_win && hit(addr, OFS_ADR_HI);
        sel.cmd_st  = in_win && hit(addr, OFS_CMD_ST);
    end
endmodule

// File: rtl/mbx_inbound.sv
module mbx_inbound
    import mbx_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              hold_clr,
    input  logic              set_wr,
    input  logic              clr_wr,
    input  logic [WORD_W-1:0] wbits,
    input  logic              fw_mbox_taken,
    output ibpulse_t          pulse,
    output logic              mbox_full
);
    always_ff @(posedge clk) begin
        if (rst) begin
            pulse <= '0;
        end else begin
            pulse.hw_cmd  <= set_wr && wbits[B_HW];
            pulse.hw_ack  <= clr_wr && wbits[B_MEM];
            pulse.fw_irq  <= set_wr && wbits[B_FWIRQ];
            pulse.ctl_rst <= set_wr && wbits[B_RST];
            pulse.mem_cmd <= set_wr && wbits[B_MEMCMD];
        end
    end

    // a new command marks the mailbox full; firmware frees it
    always_ff @(posedge clk) begin
        if (rst || hold_clr)              mbox_full <= 1'b0;
        else if (set_wr && wbits[B_HW])   mbox_full <= 1'b1;
        else if (fw_mbox_taken)           mbox_full <= 1'b0;
    end
endmodule

// File: rtl/mbx_outbound.sv
module mbx_outbound
    import mbx_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              hold_clr,
    input  logic              clr_wr,
    input  logic              mset_wr,
    input  logic              mclr_wr,
    input  logic [WORD_W-1:0] wbits,
    input  logic [NSRC-1:0]   fw_done,
    input  logic              fw_err,
    input  logic [ERR_W-1:0]  fw_err_code,
    input  logic [7:0]        fw_err_p0,
    input  logic [7:0]        fw_err_p1,
    output logic [NSRC-1:0]   ob,
    output logic [NSRC-1:0]   mask,
    output err_t              err,
    output logic              irq
);
    logic ob_bit   [NSRC];
    logic mask_bit [NSRC];

    for (genvar g = 0; g < NSRC; g++) begin : g_src
        // a post outranks a same-cycle host clear
        always_ff @(posedge clk) begin
            if (rst || hold_clr)                 ob_bit[g] <= 1'b0;
            else if (fw_done[g])                 ob_bit[g] <= 1'b1;
            else if (clr_wr && wbits[B_HW + g])  ob_bit[g] <= 1'b0;
        end

        always_ff @(posedge clk) begin
            if (rst)                             mask_bit[g] <= 1'b1;
            else if (mset_wr && wbits[B_HW + g]) mask_bit[g] <= 1'b1;
            else if (mclr_wr && wbits[B_HW + g]) mask_bit[g] <= 1'b0;
        end

        assign ob[g]   = ob_bit[g];
        assign mask[g] = mask_bit[g];
    end

    always_ff @(posedge clk) begin
        if (rst || hold_clr) begin
            err <= '0;
        end else if (fw_err) begin
            err.pend <= 1'b1;
            err.code <= fw_err_code;
            err.p0   <= fw_err_p0;
            err.p1   <= fw_err_p1;
        end else if (clr_wr && wbits[B_MEM] && wbits[B_HW]) begin
            err.pend <= 1'b0;
            err.code <= '0;
        end
    end

    assign irq = |(ob & ~mask);
endmodule

// File: rtl/mbx_doorbell_regs.sv
module mbx_doorbell_regs
    import mbx_pkg::*;
#(
    parameter int ADDR_W = 13
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    input  logic [3:0]        bus_be,
    input  logic              bus_we,
    input  logic              bus_re,
    output logic [31:0]       bus_rdata,
    input  logic              fw_mbox_taken,
    input  logic              fw_init_busy,
    input  logic              fw_hw_done,
    input  logic              fw_mem_done,
    input  logic [15:0]       fw_cmd_id,
    input  logic [15:0]       fw_cmd_status,
    input  logic              fw_err,
    input  logic [4:0]        fw_err_code,
    input  logic [7:0]        fw_err_p0,
    input  logic [7:0]        fw_err_p1,
    output logic              fw_hw_cmd,
    output logic              fw_hw_ack,
    output logic              fw_irq_req,
    output logic              fw_ctl_rst,
    output logic              fw_mem_cmd,
    output logic [63:0]       mbox_addr,
    output logic              mbox_addr_load,
    output logic              host_irq
);
    localparam int HALF_W = WORD_W / 2;

    regsel_t           sel;
    regsel_t           wsel;
    logic              in_win;
    logic [WORD_W-1:0] wmask;
    logic [WORD_W-1:0] wbits;
    ibpulse_t          pulse;
    logic              mbox_full;
    logic [NSRC-1:0]   ob_q;
    logic [NSRC-1:0]   mask_q;
    err_t              err_q;
    logic              hold_clr;
    logic [WORD_W-1:0] adr_lo_q;
    logic [WORD_W-1:0] adr_hi_q;
    logic [HALF_W-1:0] cmd_id_q;
    logic [HALF_W-1:0] cmd_st_q;
    logic [WORD_W-1:0] rd_mux;

    mbx_decode #(.ADDR_W(ADDR_W)) u_dec (
        .addr   (bus_addr),
        .in_win (in_win),
        .sel    (sel)
    );

    assign wsel     = bus_we ? sel : '0;
    assign wmask    = lane_mask(bus_be);
    assign wbits    = bus_wdata & wmask;
    assign hold_clr = pulse.ctl_rst;

    mbx_inbound u_ib (
        .clk           (clk),
        .rst           (rst),
        .hold_clr      (hold_clr),
        .set_wr        (wsel.ib_set),
        .clr_wr        (wsel.ib_clr),
        .wbits         (wbits),
        .fw_mbox_taken (fw_mbox_taken),
        .pulse         (pulse),
        .mbox_full     (mbox_full)
    );

    mbx_outbound u_ob (
        .clk         (clk),
        .rst         (rst),
        .hold_clr    (hold_clr),
        .clr_wr      (wsel.ob_clr),
        .mset_wr     (wsel.msk_set),
        .mclr_wr     (wsel.msk_clr),
        .wbits       (wbits),
        .fw_done     ({fw_mem_done, fw_hw_done}),
        .fw_err      (fw_err),
        .fw_err_code (fw_err_code),
        .fw_err_p0   (fw_err_p0),
        .fw_err_p1   (fw_err_p1),
        .ob          (ob_q),
        .mask        (mask_q),
        .err         (err_q),
        .irq         (host_irq)
    );

    // mailbox address words, merged per byte lane
    always_ff @(posedge clk) begin
        if (rst) begin
            adr_lo_q       <= '0;
            adr_hi_q       <= '0;
            mbox_addr_load <= 1'b0;
        end else begin
            if (wsel.adr_lo) adr_lo_q <= (adr_lo_q & ~wmask) | wbits;
            if (wsel.adr_hi) adr_hi_q <= (adr_hi_q & ~wmask) | wbits;
            mbox_addr_load <= wsel.adr_hi;
        end
    end

    // completion identifier and status
    always_ff @(posedge clk) begin
        if (rst || hold_clr) begin
            cmd_id_q <= '0;
            cmd_st_q <= '0;
        end else if (fw_hw_done || fw_mem_done) begin
            cmd_id_q <= fw_cmd_id;
            cmd_st_q <= fw_cmd_status;
        end
    end

    always_comb begin
        rd_mux = '0;
        unique case (1'b1)
            sel.isr:                 rd_mux[B_MEM:B_HW] = ob_q & ~mask_q;
            sel.ib_set, sel.ib_clr:  rd_mux[B_MEM:B_HW] = {fw_init_busy, mbox_full};
            sel.ob_rd, sel.ob_clr:   rd_mux[31:24]      = ob_top_byte(ob_q, err_q);
            sel.msk_set, sel.msk_clr: rd_mux[B_MEM:B_HW] = mask_q;
            sel.adr_lo:              rd_mux[15:0]       = {err_q.p1, err_q.p0};
            sel.adr_hi:              rd_mux             = adr_hi_q;
            sel.cmd_st:              rd_mux             = {cmd_st_q, cmd_id_q};
            default:                 rd_mux             = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst)         bus_rdata <= '0;
        else if (bus_re) bus_rdata <= rd_mux;
        else             bus_rdata <= '0;
    end

    assign fw_hw_cmd  = pulse.hw_cmd;
    assign fw_hw_ack  = pulse.hw_ack;
    assign fw_irq_req = pulse.fw_irq;
    assign fw_ctl_rst = pulse.ctl_rst;
    assign fw_mem_cmd = pulse.mem_cmd;
    assign mbox_addr  = {adr_hi_q, adr_lo_q};
endmodule

// File: rtl/mbx_doorbell_chk.sv
module mbx_doorbell_chk
    import mbx_pkg::*;
#(
    parameter int ADDR_W = 13
) (
    input logic              clk,
    input logic              rst,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              bus_we,
    input logic              bus_re,
    input logic [31:0]       bus_rdata,
    input logic              fw_hw_done,
    input logic              fw_mem_done,
    input logic              fw_hw_cmd,
    input logic              fw_ctl_rst,
    input logic              host_irq,
    input logic [NSRC-1:0]   ob,
    input logic [NSRC-1:0]   mask,
    input logic              err_pend
);
    localparam logic [ADDR_W-1:0] WIN = ADDR_W'(WIN_SIZE);

    assert_oob_read_zero_R1: assert property (@(posedge clk) disable iff (rst)
        (bus_re && bus_addr >= WIN) |=> bus_rdata == 32'h0);

    assert_oob_write_keeps_mask_R1: assert property (@(posedge clk) disable iff (rst)
        (bus_we && bus_addr >= WIN) |=> $stable(mask));

    assert_cmd_strobe_from_write_R2: assert property (@(posedge clk) disable iff (rst)
        fw_hw_cmd |-> $past(bus_we));

    assert_hw_post_lands_R4: assert property (@(posedge clk) disable iff (rst)
        (fw_hw_done && !fw_ctl_rst) |=> ob[0]);

    assert_mem_post_lands_R4: assert property (@(posedge clk) disable iff (rst)
        (fw_mem_done && !fw_ctl_rst) |=> ob[1]);

    assert_mask_after_reset_R5: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> mask == 2'b11);

    assert_fully_masked_quiet_R6: assert property (@(posedge clk) disable iff (rst)
        (mask == 2'b11) |-> !host_irq);

    assert_ctl_reset_clears_R11: assert property (@(posedge clk) disable iff (rst)
        fw_ctl_rst |=> (ob == '0 && !err_pend));
endmodule

bind mbx_doorbell_regs mbx_doorbell_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .bus_addr    (bus_addr),
    .bus_we      (bus_we),
    .bus_re      (bus_re),
    .bus_rdata   (bus_rdata),
    .fw_hw_done  (fw_hw_done),
    .fw_mem_done (fw_mem_done),
    .fw_hw_cmd   (fw_hw_cmd),
    .fw_ctl_rst  (fw_ctl_rst),
    .host_irq    (host_irq),
    .ob          (ob_q),
    .mask        (mask_q),
    .err_pend    (err_q.pend)
);

// File: tb/sim_mbx_doorbell_regs.sv
module sim_mbx_doorbell_regs;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [12:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [3:0]  bus_be = '0;
    logic        bus_we = 1'b0;
    logic        bus_re = 1'b0;
    logic [31:0] bus_rdata;
    logic        fw_mbox_taken = 1'b0;
    logic        fw_init_busy = 1'b0;
    logic        fw_hw_done = 1'b0;
    logic        fw_mem_done = 1'b0;
    logic [15:0] fw_cmd_id = '0;
    logic [15:0] fw_cmd_status = '0;
    logic        fw_err = 1'b0;
    logic [4:0]  fw_err_code = '0;
    logic [7:0]  fw_err_p0 = '0;
    logic [7:0]  fw_err_p1 = '0;
    logic        fw_hw_cmd, fw_hw_ack, fw_irq_req, fw_ctl_rst, fw_mem_cmd;
    logic [63:0] mbox_addr;
    logic        mbox_addr_load;
    logic        host_irq;

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;
    bit done   = 1'b0;

    always #10 clk = ~clk;

    mbx_doorbell_regs #(.ADDR_W(13)) u0 (.*);

    typedef struct packed {
        logic        wr;
        logic [12:0] addr;
        logic [31:0] data;
        logic [3:0]  be;
        logic [31:0] exp;
        logic [3:0]  req;
    } vec_t;

    localparam int NV = 23;
    localparam vec_t VEC [NV] = '{
        '{1'b0, 13'h022C, 32'h0,        4'hF, 32'h03000000, 4'd5},  // R5 reset mask
        '{1'b0, 13'h0224, 32'h0,        4'hF, 32'h00000000, 4'd4},  // R4 reset flags
        '{1'b0, 13'h0214, 32'h0,        4'hF, 32'h00000000, 4'd3},  // R3 reset inbound
        '{1'b1, 13'h0230, 32'h01000000, 4'hF, 32'h0,        4'd5},
        '{1'b0, 13'h022C, 32'h0,        4'hF, 32'h02000000, 4'd5},  // R5 clear one
        '{1'b0, 13'h0230, 32'h0,        4'hF, 32'h02000000, 4'd5},  // R5 alt address
        '{1'b1, 13'h022C, 32'h01000000, 4'hF, 32'h0,        4'd5},
        '{1'b0, 13'h022C, 32'h0,        4'hF, 32'h03000000, 4'd5},  // R5 set again
        '{1'b1, 13'h0230, 32'h03000000, 4'h7, 32'h0,        4'd12},
        '{1'b0, 13'h022C, 32'h0,        4'hF, 32'h03000000, 4'd12}, // R12 lane off
        '{1'b1, 13'h0630, 32'h03000000, 4'hF, 32'h0,        4'd1},
        '{1'b0, 13'h022C, 32'h0,        4'hF, 32'h03000000, 4'd1},  // R1 alias ignored
        '{1'b1, 13'h0510, 32'hDEADBEEF, 4'hF, 32'h0,        4'd7},
        '{1'b1, 13'h0514, 32'h00000012, 4'hF, 32'h0,        4'd7},
        '{1'b0, 13'h0514, 32'h0,        4'hF, 32'h00000012, 4'd7},  // R7 high word
        '{1'b1, 13'h0514, 32'hFFFFFFFF, 4'h2, 32'h0,        4'd12},
        '{1'b0, 13'h0514, 32'h0,        4'hF, 32'h0000FF12, 4'd12}, // R12 merge
        '{1'b0, 13'h1514, 32'h0,        4'hF, 32'h00000000, 4'd1},  // R1 far read
        '{1'b0, 13'h0700, 32'h0,        4'hF, 32'h00000000, 4'd1},  // R1 past window
        '{1'b0, 13'h0208, 32'h0,        4'hF, 32'h00000000, 4'd10}, // R10 idle
        '{1'b0, 13'h0518, 32'h0,        4'hF, 32'h00000000, 4'd8},  // R8 idle
        '{1'b1, 13'h1514, 32'h00000000, 4'hF, 32'h0,        4'd1},
        '{1'b0, 13'h0514, 32'h0,        4'hF, 32'h0000FF12, 4'd1}   // R1 write ignored
    };

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [12:0] a, input logic [31:0] d, input logic [3:0] be);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_be = be; bus_we = 1'b1;
        @(negedge clk);
        bus_we = 1'b0; bus_be = '0;
    endtask

    task automatic rd(input logic [12:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_re = 1'b1;
        @(negedge clk);
        bus_re = 1'b0;
        d = bus_rdata;
    endtask

    task automatic rd_chk(input string req, input logic [12:0] a, input logic [31:0] exp);
        logic [31:0] d;
        rd(a, d);
        chk(req, {32'h0, d}, {32'h0, exp});
    endtask

    task automatic summary;
        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    endtask

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 20000 && !done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual %0d cycles expected fewer", cyc);
            summary();
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk("R6 reset irq", {63'h0, host_irq}, 64'h0);
        chk("R2 reset strobes", {59'h0, fw_hw_cmd, fw_hw_ack, fw_irq_req, fw_ctl_rst, fw_mem_cmd}, 64'h0);
        chk("R7 reset address", mbox_addr, 64'h0);

        for (int i = 0; i < NV; i++) begin
            if (VEC[i].wr) begin
                wr(VEC[i].addr, VEC[i].data, VEC[i].be);
            end else begin
                rd_chk($sformatf("R%0d vec %0d", VEC[i].req, i), VEC[i].addr, VEC[i].exp);
            end
        end

        // R7 address output and load strobe
        chk("R7 address", mbox_addr, 64'h0000FF12_DEADBEEF);
        wr(13'h0514, 32'h0000FF12, 4'hF);
        chk("R7 load strobe", {63'h0, mbox_addr_load}, 64'h1);
        @(negedge clk);
        chk("R7 load one cycle", {63'h0, mbox_addr_load}, 64'h0);

        // R2 inbound strobes
        wr(13'h0214, 32'h01000000, 4'hF);
        chk("R2 hw cmd", {62'h0, fw_hw_cmd, fw_mem_cmd}, 64'h2);
        @(negedge clk);
        chk("R2 hw cmd one cycle", {63'h0, fw_hw_cmd}, 64'h0);
        rd_chk("R3 mailbox full", 13'h0214, 32'h01000000);
        fw_init_busy = 1'b1;
        rd_chk("R3 init busy", 13'h0218, 32'h03000000);
        @(negedge clk); fw_mbox_taken = 1'b1;
        @(negedge clk); fw_mbox_taken = 1'b0;
        rd_chk("R3 taken", 13'h0214, 32'h02000000);
        fw_init_busy = 1'b0;
        wr(13'h0218, 32'h02000000, 4'hF);
        chk("R2 hw ack", {63'h0, fw_hw_ack}, 64'h1);
        wr(13'h0214, 32'h14000000, 4'hF);
        chk("R2 irq and mem cmd", {61'h0, fw_irq_req, fw_mem_cmd, fw_hw_cmd}, 64'h6);
        wr(13'h1214, 32'h01000000, 4'hF);
        chk("R1 no strobe outside", {63'h0, fw_hw_cmd}, 64'h0);
        wr(13'h0214, 32'h01000000, 4'h7);
        chk("R12 strobe needs lane", {63'h0, fw_hw_cmd}, 64'h0);

        // R4 R6 R8 R10 completion path, mask still fully set
        @(negedge clk);
        fw_hw_done = 1'b1; fw_cmd_id = 16'h1234; fw_cmd_status = 16'h00AB;
        @(negedge clk);
        fw_hw_done = 1'b0;
        chk("R6 masked post", {63'h0, host_irq}, 64'h0);
        rd_chk("R4 hw flag", 13'h0224, 32'h01000000);
        rd_chk("R10 masked status", 13'h0208, 32'h00000000);
        wr(13'h0230, 32'h03000000, 4'hF);
        chk("R6 unmask raises irq", {63'h0, host_irq}, 64'h1);
        rd_chk("R10 unmasked status", 13'h0208, 32'h01000000);
        rd_chk("R8 id and status", 13'h0518, 32'h00AB1234);
        wr(13'h0228, 32'h01000000, 4'hF);
        chk("R6 clear drops irq", {63'h0, host_irq}, 64'h0);
        rd_chk("R4 cleared", 13'h0228, 32'h00000000);

        // R4 post beats same-cycle clear
        @(negedge clk);
        fw_mem_done = 1'b1; fw_cmd_id = 16'h5678; fw_cmd_status = 16'h0001;
        bus_addr = 13'h0228; bus_wdata = 32'h02000000; bus_be = 4'hF; bus_we = 1'b1;
        @(negedge clk);
        fw_mem_done = 1'b0; bus_we = 1'b0;
        chk("R6 mem irq", {63'h0, host_irq}, 64'h1);
        rd_chk("R4 post wins", 13'h0224, 32'h02000000);
        rd_chk("R8 mem latch", 13'h0518, 32'h00015678);
        wr(13'h0228, 32'h02000000, 4'hF);
        chk("R6 mem cleared", {63'h0, host_irq}, 64'h0);

        // R9 error reporting
        @(negedge clk);
        fw_err = 1'b1; fw_err_code = 5'b10110; fw_err_p0 = 8'h5A; fw_err_p1 = 8'hC3;
        @(negedge clk);
        fw_err = 1'b0;
        rd_chk("R9 error byte", 13'h0224, 32'hB8000000);
        rd_chk("R9 params", 13'h0510, 32'h0000C35A);
        wr(13'h0228, 32'h01000000, 4'hF);
        rd_chk("R9 single bit keeps", 13'h0224, 32'hB8000000);
        wr(13'h0228, 32'h03000000, 4'hF);
        rd_chk("R9 cleared", 13'h0224, 32'h00000000);

        // R11 controller reset
        wr(13'h0214, 32'h01000000, 4'hF);
        @(negedge clk);
        fw_hw_done = 1'b1; fw_cmd_id = 16'h9999; fw_cmd_status = 16'h7777;
        @(negedge clk);
        fw_hw_done = 1'b0;
        wr(13'h0214, 32'h08000000, 4'hF);
        chk("R11 reset strobe", {63'h0, fw_ctl_rst}, 64'h1);
        fw_mem_done = 1'b1;
        @(negedge clk);
        fw_mem_done = 1'b0;
        rd_chk("R11 flags cleared", 13'h0224, 32'h00000000);
        rd_chk("R11 status cleared", 13'h0518, 32'h00000000);
        rd_chk("R11 mailbox full cleared", 13'h0214, 32'h00000000);
        rd_chk("R11 mask kept", 13'h022C, 32'h00000000);
        chk("R11 address kept", mbox_addr, 64'h0000FF12_DEADBEEF);
        chk("R11 irq low", {63'h0, host_irq}, 64'h0);

        summary();
    end
endmodule